// File: doc/BRIEF.md
# Pulse-Swallow Counter Pair

This block holds the two digital counters of an integer-N pulse-swallow frequency divider. It counts prescaler output pulses. A program counter sets the length of one divide cycle. A swallow counter decides how many of those pulses pass while the dual-modulus prescaler is in its first modulus. After that, the swallow counter raises modulus control, which switches the prescaler to its other modulus. The swallow counter then freezes until the cycle ends. At the end of every cycle the block emits a one-clock pulse to the phase detector. The overall division follows N·P + S.

The counters are synchronous and run on the block clock. Each prescaler output pulse arrives as a one-cycle `tick_i` and acts as a count enable. Both settings are written as count-minus-one: `prog_val_i = P-1` and `swal_val_i = S-1`. Each setting is captured into a shadow register at the end-of-cycle tick, so a cycle never mixes an old setting with a new one. Between reset and the first tick, the shadows follow the inputs.

Top module: `pulse_swallow_ctr`

## Requirements
- R1: While reset is asserted and after it is released, `div_pulse_o` and `mod_ctl_o` are low until the first tick.
- R2: The tick that finds the program count equal to the captured program value is the end-of-cycle tick. It drives `div_pulse_o` high for exactly the following clock cycle. This repeats every P = `prog_val_i`+1 ticks.
- R3: After an end-of-cycle tick the program count restarts from zero. With `prog_val_i` = 0, every tick is an end-of-cycle tick.
- R4: `mod_ctl_o` rises on the clock after tick number S = `swal_val_i`+1 of a cycle. It stays high, with the swallow count frozen, until the end-of-cycle tick.
- R5: The end-of-cycle tick clears `mod_ctl_o` on the same edge that raises `div_pulse_o`, so the two are never high together.
- R6: When S >= P, `mod_ctl_o` stays low for the whole cycle.
- R7: A change of `swal_val_i` in the middle of a cycle has no effect until the next cycle. It is captured at the end-of-cycle tick.
- R8: A change of `prog_val_i` in the middle of a cycle has no effect until the next cycle. It is captured at the end-of-cycle tick.
- R9: In a cycle without a tick, `mod_ctl_o` keeps its value and `div_pulse_o` is low.
- R10: With P=77 and S=6, modulus control is high during 71 of the 77 ticks of each cycle. Each cycle ends after 77 ticks, which gives the N·P+S ratio in the prescaler.
- R11: The first cycle after reset uses the settings present at the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable for each prescaler output pulse |
| prog_val_i | input | 7 | Program setting, P-1 |
| swal_val_i | input | 6 | Swallow setting, S-1 |
| mod_ctl_o | output | 1 | Modulus control to the prescaler |
| div_pulse_o | output | 1 | End-of-cycle pulse to the phase detector |

## Verification
The assertions assume that `tick_i` is a clean synchronous enable and is low while reset is asserted. They also assume that the settings change only between edges. The bench drives every input just after the falling edge and holds `tick_i` for a single clock. It also puts an idle cycle after each tick, so the hold-without-tick property is exercised all the time. Settings are changed both at cycle boundaries and mid-cycle, and the expected outputs come from a tick-count model that captures settings only at end-of-cycle.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int unsigned PROG_W = 7;
  localparam int unsigned SWAL_W = 6;
endpackage

// File: rtl/ps_shadow.sv
module ps_shadow #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ps_prog_ctr.sv
module ps_prog_ctr #(
  parameter int unsigned W = ps_pkg::PROG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] term_i,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o
);
  assign wrap_o = tick_i && (cnt_o == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (wrap_o)  cnt_o <= '0;
    else if (tick_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ps_swal_ctr.sv
module ps_swal_ctr #(
  parameter int unsigned W = ps_pkg::SWAL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] term_i,
  output logic         mod_o,
  output logic [W-1:0] cnt_o
);
  logic step;
  // enable gated by inverse of modulus control: count freezes once reached
  assign step = tick_i && !mod_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      mod_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      mod_o <= 1'b0;
    end else if (step) begin
      if (cnt_o == term_i) mod_o <= 1'b1;
      else                 cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pulse_swallow_ctr.sv
module pulse_swallow_ctr #(
  parameter int unsigned PROG_W = ps_pkg::PROG_W,
  parameter int unsigned SWAL_W = ps_pkg::SWAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [PROG_W-1:0] prog_val_i,
  input  logic [SWAL_W-1:0] swal_val_i,
  output logic              mod_ctl_o,
  output logic              div_pulse_o
);
  logic              arm_q;
  logic              wrap;
  logic              load;
  logic [PROG_W-1:0] prog_q, prog_eff, prog_cnt;
  logic [SWAL_W-1:0] swal_q, swal_eff, swal_cnt;

  // until the first tick the shadows follow the inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= 1'b1;
    else if (tick_i) arm_q <= 1'b0;
  end

  assign load     = arm_q || wrap;
  assign prog_eff = arm_q ? prog_val_i : prog_q;
  assign swal_eff = arm_q ? swal_val_i : swal_q;

  ps_shadow #(.W(PROG_W)) u_prog_sh (
    .clk_i, .rst_ni, .load_i(load), .d_i(prog_val_i), .q_o(prog_q)
  );

  ps_shadow #(.W(SWAL_W)) u_swal_sh (
    .clk_i, .rst_ni, .load_i(load), .d_i(swal_val_i), .q_o(swal_q)
  );

  ps_prog_ctr #(.W(PROG_W)) u_prog (
    .clk_i, .rst_ni, .tick_i, .term_i(prog_eff), .wrap_o(wrap), .cnt_o(prog_cnt)
  );

  ps_swal_ctr #(.W(SWAL_W)) u_swal (
    .clk_i, .rst_ni, .tick_i, .clr_i(wrap), .term_i(swal_eff),
    .mod_o(mod_ctl_o), .cnt_o(swal_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_pulse_o <= 1'b0;
    else         div_pulse_o <= wrap;
  end
endmodule

module pulse_swallow_ctr_chk #(
  parameter int unsigned PROG_W = 7,
  parameter int unsigned SWAL_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              mod_ctl_o,
  input logic              div_pulse_o,
  input logic [PROG_W-1:0] prog_cnt,
  input logic [PROG_W-1:0] prog_eff,
  input logic [SWAL_W-1:0] swal_cnt
);
  // R2
  pulse_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> $past(tick_i));
  // R9
  mod_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(mod_ctl_o));
  // R5
  end_clears_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> !mod_ctl_o);
  // R4
  swal_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_ctl_o && $past(mod_ctl_o)) |-> $stable(swal_cnt));
  // R3
  prog_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_cnt <= prog_eff);
endmodule

bind pulse_swallow_ctr pulse_swallow_ctr_chk #(.PROG_W(PROG_W), .SWAL_W(SWAL_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .mod_ctl_o, .div_pulse_o,
  .prog_cnt(prog_cnt), .prog_eff(prog_eff), .swal_cnt(swal_cnt)
);

// File: tb/pulse_swallow_ctr_test.sv
`timescale 1ns/1ps
module pulse_swallow_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] prog_val = 7'd4;
  logic [5:0] swal_val = 6'd1;
  logic       mod_ctl, div_pulse;

  int checks = 0;
  int errors = 0;

  // model state
  int  k = 0;
  int  pm = 0;
  int  sm = 0;
  bit  armed = 1'b1;
  int  mod_ticks = 0;
  int  cycles_done = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_ctr uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .prog_val_i(prog_val), .swal_val_i(swal_val),
    .mod_ctl_o(mod_ctl), .div_pulse_o(div_pulse)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one tick then one idle cycle, both checked against the model
  task automatic step(input string tag);
    logic ep, em;
    tick = 1'b1;
    if (armed) begin
      pm = prog_val + 1; sm = swal_val + 1; armed = 1'b0;
    end
    k++;
    if (k == pm) begin
      ep = 1'b1; em = 1'b0; k = 0; cycles_done++;
      pm = prog_val + 1; sm = swal_val + 1;
    end else begin
      ep = 1'b0; em = (k >= sm);
    end
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    if (em) mod_ticks++;
    chk(tag, "div_pulse", div_pulse, ep);
    chk(tag, "mod_ctl", mod_ctl, em);
    @(posedge clk); @(negedge clk);
    chk({tag, "/R9"}, "div_pulse idle", div_pulse, 1'b0);
    chk({tag, "/R9"}, "mod_ctl idle", mod_ctl, em);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0;
    k = 0; armed = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "div_pulse in reset", div_pulse, 1'b0);
    chk("R1", "mod_ctl in reset", mod_ctl, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "div_pulse after reset", div_pulse, 1'b0);
    chk("R1", "mod_ctl after reset", mod_ctl, 1'b0);
  endtask

  task automatic test_first_cycle();
    prog_val = 7'd9; swal_val = 6'd2;
    do_reset();
    @(negedge clk);
    prog_val = 7'd5; swal_val = 6'd1;  // values at first tick win
    for (int i = 0; i < 18; i++) step("R11");
  endtask

  task automatic test_basic();
    for (int i = 0; i < 20; i++) step("R2_R4");
  endtask

  task automatic test_every_tick();
    prog_val = 7'd0; swal_val = 6'd0;
    for (int i = 0; i < 8; i++) step("R3");
  endtask

  task automatic test_no_swallow();
    prog_val = 7'd3; swal_val = 6'd7;
    for (int i = 0; i < 4; i++) step("R3");
    for (int i = 0; i < 12; i++) step("R6");
  endtask

  task automatic test_mid_change();
    prog_val = 7'd6; swal_val = 6'd2;
    while (k != 0 || armed) step("R5");
    for (int i = 0; i < 7; i++) step("R5");
    step("R7"); step("R7");
    swal_val = 6'd4;
    for (int i = 0; i < 12; i++) step("R7");
    prog_val = 7'd2; swal_val = 6'd0;
    step("R8");
    prog_val = 7'd10;  // mid-cycle
    for (int i = 0; i < 15; i++) step("R8");
  endtask

  task automatic test_example();
    prog_val = 7'd76; swal_val = 6'd5;
    while (k != 0) step("R10");
    for (int i = 0; i < 77; i++) step("R10");  // flush setting into shadow
    mod_ticks = 0;
    for (int i = 0; i < 77; i++) step("R10");
    checks++;
    if (mod_ticks != 71 || k != 0) begin
      errors++;
      $display("FAIL R10 mod_ticks actual=%0d expected=71 (k=%0d)", mod_ticks, k);
    end
  endtask

  task automatic test_max();
    prog_val = 7'd127; swal_val = 6'd63;
    while (k != 0) step("R4");
    for (int i = 0; i < 256; i++) step("R4");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_first_cycle();
    test_basic();
    test_every_tick();
    test_no_swallow();
    test_mid_change();
    test_example();
    test_max();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule